// File: doc/BRIEF.md
# Register Access Permission Bitmap Checker

This block decides whether a guest's access to a model-specific register has to be trapped. A caller pulses `start` with a 32-bit register index, a read/write select, the base address of a permission bitmap in memory and the enable bit taken from the general intercept vector. When the enable bit is clear, the block reports "no trap" without touching memory.

When the enable bit is set, the block folds three separate index windows into one compact bitmap that holds two bits per register. Slot 0 covers indices 0x0000_0000..0x0000_1FFF, slot 1 covers 0xC000_0000..0xC000_1FFF and slot 2 covers 0xC001_0000..0xC001_1FFF. It computes a byte address and a bit position within that byte, and fetches one byte over a request/response memory port. The selected bit decides the outcome. An index outside every window always traps, and no memory read is made for it.

The memory request side is a valid/ready channel. The block raises `mem_req_valid` and holds it, with the address unchanged, until `mem_req_ready` is sampled high. Exactly one byte is requested per lookup. The response side has no back-pressure: the block always accepts the single `mem_rsp_valid` beat that follows its accepted request.

Top module: `msr_perm_check`

## Requirements
- R1: During and straight after reset, `done`, `exit_req` and `mem_req_valid` are 0.
- R2: With the enable set, an index in 0x0000_0000..0x0000_1FFF reads the byte at base + (index*2 + rw)/8 and tests bit (index*2 + rw) mod 8.
- R3: With the enable set, an index in 0xC000_0000..0xC000_1FFF uses bit offset (8192 + index - 0xC000_0000)*2 + rw, with the same byte/bit split as R2.
- R4: With the enable set, an index in 0xC001_0000..0xC001_1FFF uses bit offset (16384 + index - 0xC001_0000)*2 + rw, with the same byte/bit split as R2.
- R5: rw = 0 (read) selects the low bit of the register's pair and rw = 1 (write) selects the high bit. `exit_req` is 1 with `done` exactly when the fetched bit is 1.
- R6: With the enable set, an index outside all three windows gives `done` with `exit_req` = 1 two cycles after `start` is sampled, and no memory request is made.
- R7: With the enable clear, every index gives `done` with `exit_req` = 0 two cycles after `start` is sampled, and no memory request is made.
- R8: Once raised, `mem_req_valid` stays high with `mem_req_addr` stable until `mem_req_ready` is sampled high. A lookup makes exactly one request.
- R9: `done` is a single-cycle pulse. On the memory path it is high in the cycle after the edge that samples `mem_rsp_valid`.
- R10: A `start` pulse while a lookup is in progress is ignored. The running lookup's result and address are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| msr_idx | input | 32 | Register index |
| wr_sel | input | 1 | 0 = read access, 1 = write access |
| bitmap_base | input | ADDR_W | Byte address of the bitmap |
| msr_intercept_en | input | 1 | Register-access enable bit from the intercept vector |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Fetched bitmap byte |
| done | output | 1 | Lookup finished (one-cycle pulse) |
| exit_req | output | 1 | Trap decision, qualified by `done` |

## Verification
The hardest situation to reach from the ports is a lookup that overlaps with everything else at once. Request back-pressure stretches the request phase, the response arrives after a varying delay, and a stray `start` with a different index lands mid-lookup. The bench's behavioural memory draws `mem_req_ready` and the response latency at random every cycle. It also pulses a conflicting `start` during many lookups, so the hold rule, the one-request rule and the done timing are all checked under uneven timing. Indices at the very edges of each window, and just outside them, are driven directly.

// File: rtl/msrp_pkg.sv
package msrp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT_MEM, ST_DONE} lkup_state_e;

  localparam int unsigned IDX_W    = 32;
  localparam int unsigned NUM_WIN  = 3;
  localparam int unsigned WIN_LOG2 = 13;
  // Window k maps to bitmap slot k (slot 0 in the low bits of the vector).
  localparam logic [NUM_WIN*IDX_W-1:0] WIN_BASES =
    {32'hC001_0000, 32'hC000_0000, 32'h0000_0000};
  localparam int unsigned OFF_W = $clog2(NUM_WIN) + WIN_LOG2 + 1;
endpackage

// File: rtl/msrp_window_map.sv
module msrp_window_map #(
  parameter int unsigned IDX_W    = 32,
  parameter int unsigned NUM_WIN  = 3,
  parameter int unsigned WIN_LOG2 = 13,
  parameter logic [NUM_WIN*IDX_W-1:0] WIN_BASES = '0,
  parameter int unsigned OFF_W    = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_sel,
  output logic             in_window,
  output logic [OFF_W-1:0] bit_off
);
  localparam int unsigned SLOT_W = OFF_W - 1 - WIN_LOG2;

  logic [NUM_WIN-1:0] hit_vec;
  logic [OFF_W-1:0]   off_vec [NUM_WIN];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    logic [IDX_W-1:0] rel;
    assign rel        = idx - WIN_BASES[k*IDX_W +: IDX_W];
    assign hit_vec[k] = (rel[IDX_W-1:WIN_LOG2] == '0);
    assign off_vec[k] = hit_vec[k] ? {SLOT_W'(k), rel[WIN_LOG2-1:0], wr_sel} : '0;
  end

  always_comb begin
    in_window = |hit_vec;
    bit_off   = '0;
    for (int k = 0; k < NUM_WIN; k++) bit_off = bit_off | off_vec[k];
  end
endmodule

// File: rtl/msrp_ctrl.sv
module msrp_ctrl
  import msrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  msr_idx,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] bitmap_base,
  input  logic              msr_intercept_en,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wr_q,
  input  logic              map_hit,
  input  logic [OFF_W-1:0]  map_off,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              done,
  output logic              exit_req
);
  localparam int unsigned BYTE_W = OFF_W - 3;

  lkup_state_e       st;
  logic [ADDR_W-1:0] base_q;
  logic              en_q;
  logic              req_v;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bitpos_q;
  logic              exit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      en_q     <= 1'b0;
      req_v    <= 1'b0;
      addr_q   <= '0;
      bitpos_q <= '0;
      exit_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          idx_q  <= msr_idx;
          wr_q   <= wr_sel;
          base_q <= bitmap_base;
          en_q   <= msr_intercept_en;
          st     <= ST_ADDR;
        end
        ST_ADDR: begin
          if (!en_q) begin
            exit_q <= 1'b0;
            st     <= ST_DONE;
          end else if (!map_hit) begin
            exit_q <= 1'b1;
            st     <= ST_DONE;
          end else begin
            addr_q   <= base_q + ADDR_W'(map_off[OFF_W-1 -: BYTE_W]);
            bitpos_q <= map_off[2:0];
            req_v    <= 1'b1;
            st       <= ST_WAIT_MEM;
          end
        end
        ST_WAIT_MEM: begin
          if (req_v) begin
            if (mem_req_ready) req_v <= 1'b0;
          end else if (mem_rsp_valid) begin
            exit_q <= mem_rsp_data[bitpos_q];
            st     <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = req_v;
  assign mem_req_addr  = addr_q;
  assign done          = (st == ST_DONE);
  assign exit_req      = done & exit_q;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_MEM && !req_v && mem_rsp_valid) |=> done);

  assert_bypass_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && !(en_q && map_hit)) |=> (done && !mem_req_valid));

  assert_disabled_no_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && !en_q) |=> !exit_req);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start) |=> ($stable(idx_q) && $stable(wr_q)));
endmodule

// File: rtl/msr_perm_check.sv
module msr_perm_check
  import msrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       msr_idx,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] bitmap_base,
  input  logic              msr_intercept_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              done,
  output logic              exit_req
);
  logic [IDX_W-1:0] idx_q;
  logic             wr_q;
  logic             map_hit;
  logic [OFF_W-1:0] map_off;

  msrp_window_map #(
    .IDX_W(IDX_W), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2),
    .WIN_BASES(WIN_BASES), .OFF_W(OFF_W)
  ) i_map (
    .idx(idx_q), .wr_sel(wr_q), .in_window(map_hit), .bit_off(map_off)
  );

  msrp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .msr_idx(msr_idx),
    .wr_sel(wr_sel), .bitmap_base(bitmap_base),
    .msr_intercept_en(msr_intercept_en),
    .idx_q(idx_q), .wr_q(wr_q), .map_hit(map_hit), .map_off(map_off),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .exit_req(exit_req)
  );
endmodule

// File: tb/test_msr_perm_check.sv
module test_msr_perm_check;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       msr_idx = '0;
  logic              wr_sel = 1'b0;
  logic [ADDR_W-1:0] bitmap_base = '0;
  logic              msr_intercept_en = 1'b0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [7:0]        mem_rsp_data = '0;
  logic              done;
  logic              exit_req;

  msr_perm_check #(.ADDR_W(ADDR_W)) i_msr_perm_check (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int req_count = 0, rsp_cyc = -10;
  logic [ADDR_W-1:0] last_addr = '0;
  bit pend = 0;
  int cnt = 0;
  logic [ADDR_W-1:0] paddr = '0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    logic [7:0] m;
    m = a[10:3] * 8'd13;
    return a[7:0] ^ a[15:8] ^ m ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // behavioural bitmap memory: random ready, random response latency
  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 8'($urandom);
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_byte(paddr);
        rsp_cyc       = cyc;
        pend          = 0;
      end else cnt--;
    end
    mem_req_ready = ($urandom % 3) != 0;
    if (mem_req_valid && mem_req_ready && rst_n) begin
      pend      = 1;
      paddr     = mem_req_addr;
      last_addr = mem_req_addr;
      cnt       = $urandom % 4;
      req_count++;
    end
  end

  task automatic lookup(logic [31:0] idx, bit rw, bit en, logic [31:0] base, bit garbage);
    bit hit;
    int off, slot;
    string rtag;
    int s, rq0, t;
    logic [31:0] eaddr;
    bit eexit;
    hit = 1; slot = 0; rtag = "R6";
    if (idx <= 32'h1FFF) begin off = int'(idx) * 2; rtag = "R2"; end
    else if (idx >= 32'hC000_0000 && idx <= 32'hC000_1FFF) begin
      off = (8192 + int'(idx - 32'hC000_0000)) * 2; rtag = "R3"; end
    else if (idx >= 32'hC001_0000 && idx <= 32'hC001_1FFF) begin
      off = (16384 + int'(idx - 32'hC001_0000)) * 2; rtag = "R4"; end
    else begin hit = 0; off = 0; end
    off   = off + int'(rw);
    eaddr = base + 32'(off / 8);
    if (!en)      eexit = 0;
    else if (!hit) eexit = 1;
    else          eexit = mem_byte(eaddr)[off % 8];
    slot = slot;

    @(negedge clk);
    msr_idx = idx; wr_sel = rw; msr_intercept_en = en; bitmap_base = base;
    start = 1'b1;
    s = cyc; rq0 = req_count;
    @(negedge clk);
    if (garbage) begin  // R10: stray start during the lookup
      msr_idx = ~idx; wr_sel = ~rw; msr_intercept_en = ~en; bitmap_base = ~base;
    end
    start = garbage;
    t = 0;
    while (!done && t < 60) begin
      @(negedge clk);
      start = garbage && (t < 3);
      t++;
    end
    start = 1'b0;
    chk(done, "R9 done seen", done, 1);
    if (!en || !hit) begin
      chk(cyc == s + 2, en ? "R6 bypass latency" : "R7 bypass latency", cyc - s, 2);
      chk(req_count == rq0, en ? "R6 no request" : "R7 no request", req_count - rq0, 0);
      chk(exit_req == eexit, en ? "R6 exit" : "R7 exit", exit_req, eexit);
    end else begin
      chk(req_count == rq0 + 1, "R8 one request", req_count - rq0, 1);
      chk(last_addr == eaddr, {rtag, " byte address"}, last_addr, eaddr);
      chk(cyc == rsp_cyc + 1, "R9 done after response", cyc - rsp_cyc, 1);
      chk(exit_req == eexit, garbage ? "R10 R5 exit" : "R5 exit", exit_req, eexit);
    end
    @(negedge clk);
    chk(!done && !exit_req, "R9 done pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(!done && !exit_req && !mem_req_valid, "R1 in reset", {done, exit_req, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !exit_req && !mem_req_valid, "R1 after reset", {done, exit_req, mem_req_valid}, 0);

    // directed window edges (R2, R3, R4), outside (R6), disabled (R7)
    lookup(32'h0000_0000, 0, 1, 32'h0001_0000, 0);
    lookup(32'h0000_1FFF, 1, 1, 32'h0001_0000, 0);
    lookup(32'h0000_2000, 0, 1, 32'h0001_0000, 0);
    lookup(32'hBFFF_FFFF, 1, 1, 32'h0001_0000, 0);
    lookup(32'hC000_0000, 0, 1, 32'h0002_0004, 0);
    lookup(32'hC000_1FFF, 1, 1, 32'h0002_0004, 0);
    lookup(32'hC000_2000, 1, 1, 32'h0002_0004, 1);
    lookup(32'hC001_0000, 0, 1, 32'h0003_0000, 0);
    lookup(32'hC001_1FFF, 1, 1, 32'h0003_0000, 1);
    lookup(32'hC001_2000, 0, 1, 32'h0003_0000, 0);
    lookup(32'hFFFF_FFFF, 0, 1, 32'h0003_0000, 0);
    lookup(32'hFFFF_FFFF, 0, 0, 32'h0003_0000, 0);
    lookup(32'h0000_0123, 1, 0, 32'h0003_0000, 1);
    // R5: both halves of one pair
    lookup(32'h0000_0041, 0, 1, 32'h0000_8000, 0);
    lookup(32'h0000_0041, 1, 1, 32'h0000_8000, 0);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] idx;
      int w;
      w = $urandom % 5;
      case (w)
        0: idx = 32'h0000_0000 + ($urandom % 8192);
        1: idx = 32'hC000_0000 + ($urandom % 8192);
        2: idx = 32'hC001_0000 + ($urandom % 8192);
        3: idx = $urandom;
        default: idx = 32'hC000_0000 + ($urandom % 32'h0002_4000);
      endcase
      lookup(idx, 1'($urandom), ($urandom % 6) != 0,
             {12'h0, 20'($urandom)}, ($urandom % 3) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule